// File: doc/BRIEF.md
# Wake-up Status Register with Alert

This block holds the nine-bit status word of a three-channel low-frequency wake-up receiver. Some bits follow live conditions: channel activity, AGC activity and a configuration parity mismatch. Others record events and stay set: which channel caused a wake-up, and whether the alarm timer expired. A command interface supplies single-cycle strobes for soft reset, sleep and status read. Those strobes clear different bits.

A status read captures the whole word into a read-data register. The alarm flag clears in the same cycle, so the captured word still shows the alarm. The active-low alert output goes low while a parity mismatch is present. It also goes low while the alarm flag is set, but only if the alarm-alert enable is high.

All inputs are synchronous to `clk`. The analog front end, the AGC and the serial shifter are modelled as input levels and strobes.

Top module: `wake_status_reg`

## Requirements
- R1: While `rst_n` is low, bits 7..0 of `status` and all of `rd_data` are 0, and `alert_n` is 1 when `parity_err` is 0. The word is laid out as: bit 8 parity, bits 7/6/5 channel Z/Y/X active, bit 4 AGC active, bits 3/2/1 channel Z/Y/X wake cause, bit 0 alarm.
- R2: A channel's wake-cause bit sets on the clock edge that ends `WAKE_CNT` consecutive cycles with that channel's `ch_detect` bit high (bit 0 = X, 1 = Y, 2 = Z). A low cycle restarts the count.
- R3: Wake-cause bits stay set until `soft_rst`. A `soft_rst` clears bits 7..1 at the next edge and restarts the detection counts.
- R4: `alarm_tmo` sets bit 0 at the next edge. A `status_rd` with no `alarm_tmo` in the same cycle clears it at the next edge. When both occur in one cycle, the bit stays set. Soft reset leaves it unchanged.
- R5: On `status_rd`, `rd_data` loads the value `status` had in that cycle, which is before the alarm clear. Otherwise `rd_data` holds its value.
- R6: `alert_n` = NOT(`parity_err` OR (bit 0 AND `alarm_alert_en`)), without clock delay.
- R7: Bit 8 equals `parity_err` without clock delay and is unaffected by `soft_rst`.
- R8: Each channel-active bit equals the matching `ch_pass` bit one edge later, except in standby. `sleep_cmd` enters standby at the next edge, and from the edge after that the active bits read 0. A wake-cause set on any channel leaves standby. `sleep_cmd` wins if both happen in the same cycle.
- R9: Bit 4 equals `agc_strong` one edge later, or 0 on the edge following `soft_rst`.
- R10: `sleep_cmd` leaves the wake-cause bits and the alarm bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset command strobe |
| sleep_cmd | input | 1 | Sleep command strobe |
| status_rd | input | 1 | Status read command strobe |
| ch_detect | input | 3 | Per-channel detection level (Z,Y,X) |
| ch_pass | input | 3 | Per-channel passing-data level (Z,Y,X) |
| agc_strong | input | 1 | AGC reports a strong input |
| alarm_tmo | input | 1 | Alarm timer time-out strobe |
| alarm_alert_en | input | 1 | Configuration bit enabling alarm on alert |
| parity_err | input | 1 | Configuration parity mismatch level |
| status | output | 9 | Live status word |
| rd_data | output | 9 | Word captured by the last status read |
| alert_n | output | 1 | Active-low alert |

## Verification
The hardest situations to reach are the timing edges of the wake count. One is a detection that drops after exactly `WAKE_CNT`-1 cycles. The other is leaving standby through a wake-up that completes while standby is active. Directed phases hold `ch_detect` for 63 cycles, then for 64, then run a full count on another channel after a sleep command. A long random phase follows. It uses sparse strobes and detection bursts that sometimes reach the count. It also lines up alarm time-outs with reads in the same cycle. Every cycle is compared against a behavioural model.

// File: rtl/wake_status_reg.sv
module wake_status_reg #(
  parameter int WAKE_CNT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       sleep_cmd,
  input  logic       status_rd,
  input  logic [2:0] ch_detect,
  input  logic [2:0] ch_pass,
  input  logic       agc_strong,
  input  logic       alarm_tmo,
  input  logic       alarm_alert_en,
  input  logic       parity_err,
  output logic [8:0] status,
  output logic [8:0] rd_data,
  output logic       alert_n
);
  localparam int CW = (WAKE_CNT > 2) ? $clog2(WAKE_CNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAKE_CNT - 1);

  logic [CW-1:0] cnt [3];
  logic [2:0]    fire, act_q, wake_q;
  logic          agc_q, alarm_q, stby_q;

  for (genvar g = 0; g < 3; g++) begin : g_ch
    assign fire[g] = ch_detect[g] && (cnt[g] == LAST);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                   cnt[g] <= '0;
      else if (soft_rst || !ch_detect[g]) cnt[g] <= '0;
      else if (cnt[g] != LAST)      cnt[g] <= cnt[g] + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      wake_q  <= '0;
      agc_q   <= 1'b0;
      alarm_q <= 1'b0;
      stby_q  <= 1'b0;
      rd_data <= '0;
    end else begin
      act_q   <= soft_rst ? 3'b000 : (ch_pass & {3{~stby_q}});
      agc_q   <= ~soft_rst & agc_strong;
      wake_q  <= soft_rst ? 3'b000 : (wake_q | fire);
      alarm_q <= alarm_tmo | (alarm_q & ~status_rd);
      if (sleep_cmd)   stby_q <= 1'b1;
      else if (|fire)  stby_q <= 1'b0;
      if (status_rd)   rd_data <= status;
    end
  end

  assign status  = {parity_err, act_q[2], act_q[1], act_q[0], agc_q,
                    wake_q[2], wake_q[1], wake_q[0], alarm_q};
  assign alert_n = ~(parity_err | (alarm_q & alarm_alert_en));

  assert_soft_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status[7:1] == 7'd0));
  assert_wake_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((status[3:1] & $past(status[3:1])) == $past(status[3:1])));
  assert_alarm_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_tmo |=> status[0]);
  assert_alarm_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !alarm_tmo) |=> !status[0]);
  assert_read_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> (rd_data == $past(status)));
  assert_parity_alert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> !alert_n);
  assert_standby_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_cmd |=> ##1 (status[7:5] == 3'd0));
  assert_sleep_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_cmd && !soft_rst) |=> (status[3:1] == ($past(status[3:1]) | $past(fire))));
endmodule

// File: tb/wake_status_reg_tb.sv
`timescale 1ns/1ps
module wake_status_reg_tb;
  localparam int W = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic soft_rst = 0, sleep_cmd = 0, status_rd = 0, agc_strong = 0;
  logic alarm_tmo = 0, alarm_alert_en = 0, parity_err = 0;
  logic [2:0] ch_detect = 0, ch_pass = 0;
  logic [8:0] status, rd_data;
  logic alert_n;
  int checks = 0, fails = 0;

  wake_status_reg #(.WAKE_CNT(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sleep_cmd(sleep_cmd),
    .status_rd(status_rd), .ch_detect(ch_detect), .ch_pass(ch_pass),
    .agc_strong(agc_strong), .alarm_tmo(alarm_tmo),
    .alarm_alert_en(alarm_alert_en), .parity_err(parity_err),
    .status(status), .rd_data(rd_data), .alert_n(alert_n));

  always #5 clk = ~clk;

  int  m_cnt [3];
  bit  m_act [3], m_wake [3];
  bit  m_agc, m_alarm, m_stby;
  logic [8:0] m_rd;

  function automatic logic [8:0] m_word();
    return {parity_err, m_act[2], m_act[1], m_act[0], m_agc,
            m_wake[2], m_wake[1], m_wake[0], m_alarm};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) begin m_cnt[i] = 0; m_act[i] = 0; m_wake[i] = 0; end
      m_agc = 0; m_alarm = 0; m_stby = 0; m_rd = '0;
    end else begin
      bit any_fire;
      logic [8:0] snap;
      snap = m_word();
      any_fire = 0;
      for (int i = 0; i < 3; i++) begin
        bit f;
        f = ch_detect[i] && (m_cnt[i] >= W - 1);
        any_fire |= f;
        if (soft_rst || !ch_detect[i]) m_cnt[i] = 0;
        else if (m_cnt[i] < W - 1) m_cnt[i]++;
        m_wake[i] = soft_rst ? 0 : (m_wake[i] | f);
        m_act[i]  = soft_rst ? 0 : (ch_pass[i] && !m_stby);
      end
      m_agc = soft_rst ? 0 : agc_strong;
      if (alarm_tmo) m_alarm = 1;
      else if (status_rd) m_alarm = 0;
      if (status_rd) m_rd = snap;
      if (sleep_cmd) m_stby = 1;
      else if (any_fire) m_stby = 0;
    end
  end

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [8:0] e;
    e = m_word();
    chk("R7 parity bit", 9'(status[8]), 9'(e[8]));
    chk("R8 channel active", 9'(status[7:5]), 9'(e[7:5]));
    chk("R9 agc active", 9'(status[4]), 9'(e[4]));
    chk("R2 R3 wake cause", 9'(status[3:1]), 9'(e[3:1]));
    chk("R4 alarm", 9'(status[0]), 9'(e[0]));
    chk("R5 read data", rd_data, m_rd);
    chk("R6 alert", 9'(alert_n), 9'(!(parity_err || (e[0] && alarm_alert_en))));
  endtask

  task automatic cyc(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [2:0] keep;
    repeat (3) @(negedge clk);
    chk("R1 reset status", 9'(status[7:0]), 9'h0);
    chk("R1 reset rd_data", rd_data, 9'h0);
    chk("R1 reset alert", 9'(alert_n), 9'h1);
    rst_n = 1;
    cyc(2);
    ch_detect = 3'b001; cyc(63);
    ch_detect = 3'b000; cyc(1);
    chk("R2 no wake after 63", 9'(status[1]), 9'h0);
    ch_detect = 3'b001; cyc(63);
    chk("R2 not yet at 63", 9'(status[1]), 9'h0);
    cyc(1);
    chk("R2 wake at 64", 9'(status[1]), 9'h1);
    ch_detect = 3'b000; ch_pass = 3'b111; agc_strong = 1; cyc(3);
    chk("R3 wake sticky", 9'(status[3:1]), 9'h1);
    keep = status[3:1];
    sleep_cmd = 1; cyc(1); sleep_cmd = 0; cyc(1);
    chk("R8 standby drops active", 9'(status[7:5]), 9'h0);
    chk("R10 sleep keeps wake", 9'(status[3:1]), 9'(keep));
    ch_detect = 3'b100; cyc(64); ch_detect = 3'b000; cyc(2);
    chk("R8 wake leaves standby", 9'(status[7:5]), 9'h7);
    alarm_tmo = 1; cyc(1); alarm_tmo = 0; alarm_alert_en = 1; cyc(1);
    chk("R6 alarm alert", 9'(alert_n), 9'h0);
    status_rd = 1; cyc(1); status_rd = 0;
    chk("R5 read sees alarm", 9'(rd_data[0]), 9'h1);
    chk("R4 read clears alarm", 9'(status[0]), 9'h0);
    alarm_tmo = 1; status_rd = 1; cyc(1); alarm_tmo = 0; status_rd = 0;
    chk("R4 event wins over clear", 9'(status[0]), 9'h1);
    parity_err = 1; soft_rst = 1; cyc(1); soft_rst = 0;
    chk("R7 parity live", 9'(status[8]), 9'h1);
    chk("R3 soft reset clears", 9'(status[7:1]), 9'h0);
    chk("R4 soft reset keeps alarm", 9'(status[0]), 9'h1);
    parity_err = 0; cyc(1);
    for (int t = 0; t < 6000; t++) begin
      soft_rst   = ($urandom_range(0, 199) == 0);
      sleep_cmd  = ($urandom_range(0, 99) == 0);
      status_rd  = ($urandom_range(0, 19) == 0);
      alarm_tmo  = ($urandom_range(0, 29) == 0);
      parity_err = ($urandom_range(0, 39) == 0);
      if ($urandom_range(0, 7) == 0) alarm_alert_en = $urandom;
      if ($urandom_range(0, 9) == 0) ch_pass = 3'($urandom);
      if ($urandom_range(0, 9) == 0) agc_strong = $urandom;
      for (int i = 0; i < 3; i++)
        if ($urandom_range(0, 79) == 0) ch_detect[i] = ~ch_detect[i];
      cyc(1);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule